// File: doc/BRIEF.md
# Branch Speculate-and-Squash Controller

This block governs control hazards in a five-stage in-order pipeline whose stages are fetch, decode, execute, memory and writeback. Fetch assumes that every conditional branch falls through. The fetch PC therefore keeps stepping by one until a branch is proven taken. In execute, the block's arithmetic part adds the sign-extended offset to the branch's PC+1 to form the target, and it compares the two register operands for equality. The surrounding pipeline carries both results into the execute/memory pipeline register.

When a branch-if-equal sits in the memory stage with its equality flag set, the block loads the target into the fetch PC on the next clock edge. In the same cycle it turns the three younger instructions into noops by asserting the flush controls of the IF/ID, ID/EX and EX/Mem registers. None of those wrong-path instructions reaches writeback. A branch that is not taken, and every other opcode, behaves like a noop for this block.

The block also takes the data-hazard stall request. A stall holds the PC and IF/ID and injects a bubble into ID/EX. A squash in the same cycle overrides the stall and releases the held enables. The block owns the fetch PC register, which resets synchronously to a parameterised vector.

Top module: `branch_squash_ctrl`

## Requirements
- R1: While rst_n is low, pc_sel reads 3, all three flush outputs are 1 and ifid_en is 1. A rising edge with rst_n low loads fetch_pc with RESET_PC (default 0).
- R2: With no taken branch and no stall, pc_sel reads 0, all flushes are 0 and ifid_en is 1. The next edge sets fetch_pc to fetch_pc+1 modulo 2^PC_W, so 0xFFFF wraps to 0x0000.
- R3: A taken branch is mem_opcode equal to 4 with mem_equal at 1. In that cycle pc_sel reads 2 and flush_ifid, flush_idex and flush_exmem are all 1. On the very next edge fetch_pc becomes mem_target.
- R4: mem_opcode 4 with mem_equal at 0 behaves exactly as in R2.
- R5: For any mem_opcode other than 4 (0 add, 1 nand, 2 load, 3 store, 5 jump-and-link, 6 halt, 7 noop), mem_equal is ignored and the outputs follow R2 or R6.
- R6: With hazard_stall at 1 and no taken branch, pc_sel reads 1, ifid_en is 0, flush_idex is 1, and flush_ifid and flush_exmem are 0. fetch_pc keeps its value across the next edge.
- R7: A taken branch together with hazard_stall gives the R3 outputs with ifid_en at 1. The squash wins and fetch_pc loads mem_target.
- R8: ex_target equals ex_pc_plus1 plus ex_offset sign-extended from OFF_W bits, modulo 2^PC_W.
- R9: ex_equal is 1 exactly when ex_val_a equals ex_val_b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hazard_stall | input | 1 | Data-hazard stall request from the decode-stage detector |
| ex_pc_plus1 | input | PC_W | PC+1 of the instruction in execute |
| ex_offset | input | OFF_W | Raw branch offset field in execute |
| ex_val_a | input | DATA_W | First register operand in execute |
| ex_val_b | input | DATA_W | Second register operand in execute |
| mem_opcode | input | 3 | Opcode held in the EX/Mem register |
| mem_equal | input | 1 | Equality flag held in the EX/Mem register |
| mem_target | input | PC_W | Branch target held in the EX/Mem register |
| ex_target | output | PC_W | Computed branch target for the EX/Mem register |
| ex_equal | output | 1 | Operand equality for the EX/Mem register |
| fetch_pc | output | PC_W | Current fetch address |
| pc_sel | output | 2 | PC source: 0 step, 1 hold, 2 target, 3 reset |
| ifid_en | output | 1 | IF/ID load enable |
| flush_ifid | output | 1 | Replace the next IF/ID content with a noop |
| flush_idex | output | 1 | Replace the next ID/EX content with a noop |
| flush_exmem | output | 1 | Replace the next EX/Mem content with a noop |

## Verification
A squash and a data-hazard stall can land in the same cycle. They then contend for the PC and IF/ID enables and for the ID/EX bubble. The random phase raises hazard_stall about a third of the time, independently of a branch-if-equal with its flag set in the memory slot, so the two meet often. A directed case also forces the overlap. The bench judges each overlap by requiring the target on the following edge, all three flushes asserted and ifid_en released. A stall alone must instead hold the PC and bubble only ID/EX.

// File: rtl/brsq_pkg.sv
// Package: shared types for the branch squash controller.
// Assumes a 3-bit opcode in the EX/Mem register.
package brsq_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_NAND = 3'd1,
        OP_LW   = 3'd2,
        OP_SW   = 3'd3,
        OP_BEQ  = 3'd4,
        OP_JALR = 3'd5,
        OP_HALT = 3'd6,
        OP_NOOP = 3'd7
    } opcode_e;

    typedef enum logic [1:0] {
        PCS_STEP   = 2'd0,
        PCS_HOLD   = 2'd1,
        PCS_TARGET = 2'd2,
        PCS_RESET  = 2'd3
    } pc_sel_e;

    // Pipeline slots that a squash can clear, youngest first.
    localparam int SLOT_IFID  = 0;
    localparam int SLOT_IDEX  = 1;
    localparam int SLOT_EXMEM = 2;
    localparam int NUM_SLOTS  = 3;

endpackage

// File: rtl/brsq_target_calc.sv
// Module: execute-stage branch arithmetic.
// Forms PC+1+sext(offset) and tests two operands for equality.
// Assumes OFF_W <= PC_W. Everything here is combinational.
module brsq_target_calc #(
    parameter int PC_W   = 16,
    parameter int OFF_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic [PC_W-1:0]   pc_plus1,
    input  logic [OFF_W-1:0]  offset,
    input  logic [DATA_W-1:0] val_a,
    input  logic [DATA_W-1:0] val_b,
    output logic [PC_W-1:0]   target,
    output logic              equal
);

    localparam int EXT_W = PC_W - OFF_W;

    logic [PC_W-1:0] offset_ext;

    // Pick the sign-extension form that the width ratio allows.
    generate
        if (EXT_W > 0) begin : g_widen
            assign offset_ext = {{EXT_W{offset[OFF_W-1]}}, offset};
        end else begin : g_same
            assign offset_ext = offset[PC_W-1:0];
        end
    endgenerate

    // Target address and operand comparison.
    always_comb begin
        target = pc_plus1 + offset_ext;
        equal  = (val_a == val_b);
    end

endmodule

// File: rtl/brsq_resolve.sv
// Module: memory-stage branch resolution.
// Decides taken or hold and picks the PC source.
// Assumes only the branch-if-equal opcode can redirect; all others fall through.
module brsq_resolve
    import brsq_pkg::*;
(
    input  logic       rst_n,
    input  logic [2:0] opcode,
    input  logic       equal,
    input  logic       stall,
    output logic       taken,
    output logic       hold,
    output pc_sel_e    sel
);

    opcode_e op;

    // Decode the slot opcode and rank reset, squash, stall and step.
    always_comb begin
        op    = opcode_e'(opcode);
        taken = rst_n && (op == OP_BEQ) && equal;
        hold  = rst_n && stall && !taken;
        if (!rst_n)
            sel = PCS_RESET;
        else if (taken)
            sel = PCS_TARGET;
        else if (hold)
            sel = PCS_HOLD;
        else
            sel = PCS_STEP;
    end

endmodule

// File: rtl/brsq_squash_gen.sv
// Module: per-slot flush generation and IF/ID enable.
// A slot is flushed on reset or squash. Slots in BUBBLE_MASK are also flushed on a stall.
// Assumes the resolver never raises taken and hold together.
module brsq_squash_gen #(
    parameter int                  NUM_SLOTS   = 3,
    parameter logic [NUM_SLOTS-1:0] BUBBLE_MASK = 3'b010
) (
    input  logic                 in_reset,
    input  logic                 taken,
    input  logic                 hold,
    output logic [NUM_SLOTS-1:0] flush,
    output logic                 ifid_en
);

    // One flush term per pipeline slot.
    generate
        for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
            if (BUBBLE_MASK[s]) begin : g_bubble
                assign flush[s] = in_reset | taken | hold;
            end else begin : g_plain
                assign flush[s] = in_reset | taken;
            end
        end
    endgenerate

    // IF/ID is held only by a stall that no squash overrides.
    always_comb begin
        ifid_en = !hold;
    end

endmodule

// File: rtl/brsq_fetch_pc.sv
// Module: fetch PC register.
// Steps, holds, loads a target or loads the reset vector as selected.
// Assumes synchronous active-low reset and wrap-around modulo 2^PC_W.
module brsq_fetch_pc
    import brsq_pkg::*;
#(
    parameter int              PC_W     = 16,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  pc_sel_e         sel,
    input  logic [PC_W-1:0] target,
    output logic [PC_W-1:0] pc
);

    logic [PC_W-1:0] pc_next;

    // Next fetch address from the selected source.
    always_comb begin
        unique case (sel)
            PCS_STEP:   pc_next = pc + PC_W'(1);
            PCS_HOLD:   pc_next = pc;
            PCS_TARGET: pc_next = target;
            default:    pc_next = RESET_PC;
        endcase
    end

    // PC register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc <= RESET_PC;
        else
            pc <= pc_next;
    end

endmodule

// File: rtl/branch_squash_ctrl.sv
// Module: top of the not-taken speculation and squash controller.
// Execute computes the target and equality. The memory stage resolves the branch.
// A taken branch redirects fetch on the next edge and flushes three younger slots.
// Assumes the pipeline places ex_target/ex_equal into the EX/Mem register itself.
module branch_squash_ctrl
    import brsq_pkg::*;
#(
    parameter int              PC_W     = 16,
    parameter int              OFF_W    = 8,
    parameter int              DATA_W   = 32,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hazard_stall,
    input  logic [PC_W-1:0]   ex_pc_plus1,
    input  logic [OFF_W-1:0]  ex_offset,
    input  logic [DATA_W-1:0] ex_val_a,
    input  logic [DATA_W-1:0] ex_val_b,
    input  logic [2:0]        mem_opcode,
    input  logic              mem_equal,
    input  logic [PC_W-1:0]   mem_target,
    output logic [PC_W-1:0]   ex_target,
    output logic              ex_equal,
    output logic [PC_W-1:0]   fetch_pc,
    output logic [1:0]        pc_sel,
    output logic              ifid_en,
    output logic              flush_ifid,
    output logic              flush_idex,
    output logic              flush_exmem
);

    localparam logic [NUM_SLOTS-1:0] STALL_BUBBLES = NUM_SLOTS'(1) << SLOT_IDEX;

    logic                 taken;
    logic                 hold;
    pc_sel_e              sel;
    logic [NUM_SLOTS-1:0] flush_vec;

    brsq_target_calc #(
        .PC_W   (PC_W),
        .OFF_W  (OFF_W),
        .DATA_W (DATA_W)
    ) u_calc (
        .pc_plus1 (ex_pc_plus1),
        .offset   (ex_offset),
        .val_a    (ex_val_a),
        .val_b    (ex_val_b),
        .target   (ex_target),
        .equal    (ex_equal)
    );

    brsq_resolve u_resolve (
        .rst_n  (rst_n),
        .opcode (mem_opcode),
        .equal  (mem_equal),
        .stall  (hazard_stall),
        .taken  (taken),
        .hold   (hold),
        .sel    (sel)
    );

    brsq_squash_gen #(
        .NUM_SLOTS   (NUM_SLOTS),
        .BUBBLE_MASK (STALL_BUBBLES)
    ) u_squash (
        .in_reset (!rst_n),
        .taken    (taken),
        .hold     (hold),
        .flush    (flush_vec),
        .ifid_en  (ifid_en)
    );

    brsq_fetch_pc #(
        .PC_W     (PC_W),
        .RESET_PC (RESET_PC)
    ) u_pc (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (sel),
        .target (mem_target),
        .pc     (fetch_pc)
    );

    // Fan the slot vector out to the named flush pins.
    always_comb begin
        pc_sel      = sel;
        flush_ifid  = flush_vec[SLOT_IFID];
        flush_idex  = flush_vec[SLOT_IDEX];
        flush_exmem = flush_vec[SLOT_EXMEM];
    end

endmodule

// File: rtl/brsq_checker.sv
// Module: property checker for branch_squash_ctrl, attached by bind.
// Derives taken and stall from the ports and checks outputs over time.
module brsq_checker #(
    parameter int PC_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            hazard_stall,
    input logic [2:0]      mem_opcode,
    input logic            mem_equal,
    input logic [PC_W-1:0] mem_target,
    input logic [PC_W-1:0] fetch_pc,
    input logic [1:0]      pc_sel,
    input logic            ifid_en,
    input logic            flush_ifid,
    input logic            flush_idex,
    input logic            flush_exmem
);

    logic br_hit;
    assign br_hit = (mem_opcode == 3'd4) && mem_equal;

    AST_REDIRECT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        br_hit |=> fetch_pc == $past(mem_target)); // R3

    AST_SQUASH_TRIO: assert property (@(posedge clk) disable iff (!rst_n)
        br_hit |-> (flush_ifid && flush_idex && flush_exmem && pc_sel == 2'd2)); // R3

    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (!br_hit && !hazard_stall) |=> fetch_pc == $past(fetch_pc) + PC_W'(1)); // R2

    AST_QUIET_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (!br_hit && !hazard_stall) |-> !(flush_ifid || flush_idex || flush_exmem)); // R4

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (hazard_stall && !br_hit) |=> $stable(fetch_pc)); // R6

    AST_STALL_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (hazard_stall && !br_hit) |-> (flush_idex && !flush_ifid && !flush_exmem && !ifid_en)); // R6

    AST_SQUASH_OVER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (hazard_stall && br_hit) |-> ifid_en); // R7

endmodule

bind branch_squash_ctrl brsq_checker #(.PC_W(PC_W)) u_brsq_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .hazard_stall (hazard_stall),
    .mem_opcode   (mem_opcode),
    .mem_equal    (mem_equal),
    .mem_target   (mem_target),
    .fetch_pc     (fetch_pc),
    .pc_sel       (pc_sel),
    .ifid_en      (ifid_en),
    .flush_ifid   (flush_ifid),
    .flush_idex   (flush_idex),
    .flush_exmem  (flush_exmem)
);

// File: tb/branch_squash_ctrl_test.sv
`timescale 1ns/1ps
module branch_squash_ctrl_test;

    localparam int PC_W   = 16;
    localparam int OFF_W  = 8;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              hazard_stall;
    logic [PC_W-1:0]   ex_pc_plus1;
    logic [OFF_W-1:0]  ex_offset;
    logic [DATA_W-1:0] ex_val_a, ex_val_b;
    logic [2:0]        mem_opcode;
    logic              mem_equal;
    logic [PC_W-1:0]   mem_target;
    logic [PC_W-1:0]   ex_target;
    logic              ex_equal;
    logic [PC_W-1:0]   fetch_pc;
    logic [1:0]        pc_sel;
    logic              ifid_en, flush_ifid, flush_idex, flush_exmem;

    int n_checks = 0;
    int n_fail   = 0;
    logic [PC_W-1:0] model_pc = '0;

    always #2.5 clk = ~clk;

    branch_squash_ctrl #(.PC_W(PC_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) uut (
        .clk(clk), .rst_n(rst_n), .hazard_stall(hazard_stall),
        .ex_pc_plus1(ex_pc_plus1), .ex_offset(ex_offset),
        .ex_val_a(ex_val_a), .ex_val_b(ex_val_b),
        .mem_opcode(mem_opcode), .mem_equal(mem_equal), .mem_target(mem_target),
        .ex_target(ex_target), .ex_equal(ex_equal), .fetch_pc(fetch_pc),
        .pc_sel(pc_sel), .ifid_en(ifid_en), .flush_ifid(flush_ifid),
        .flush_idex(flush_idex), .flush_exmem(flush_exmem)
    );

    function automatic logic [PC_W-1:0] exp_target(logic [PC_W-1:0] p1, logic [OFF_W-1:0] off);
        int signed so = int'($signed(off));
        return PC_W'(int'(p1) + so);
    endfunction

    function automatic bit exp_taken(logic [2:0] op, logic eq);
        return (op == 3'd4) && eq;
    endfunction

    // Expected {pc_sel, ifid_en, flush_ifid, flush_idex, flush_exmem}.
    function automatic logic [5:0] exp_ctl(logic rn, logic [2:0] op, logic eq, logic st);
        if (!rn) return {2'd3, 1'b1, 3'b111};
        if (exp_taken(op, eq)) return {2'd2, 1'b1, 3'b111};
        if (st) return {2'd1, 1'b0, 3'b010};
        return {2'd0, 1'b1, 3'b000};
    endfunction

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check combinational outputs, clock, check PC.
    task automatic step(logic rn, logic st, logic [2:0] op, logic eq, logic [PC_W-1:0] tgt, string req);
        logic [5:0] ec;
        @(negedge clk);
        rst_n = rn; hazard_stall = st; mem_opcode = op; mem_equal = eq; mem_target = tgt;
        #1;
        ec = exp_ctl(rn, op, eq, st);
        check({pc_sel, ifid_en, flush_ifid, flush_idex, flush_exmem} == ec, req, "controls",
              32'({pc_sel, ifid_en, flush_ifid, flush_idex, flush_exmem}), 32'(ec));
        if (!rn) model_pc = '0;
        else if (exp_taken(op, eq)) model_pc = tgt;
        else if (!st) model_pc = model_pc + PC_W'(1);
        @(posedge clk);
        #1;
        check(fetch_pc == model_pc, req, "fetch_pc", 32'(fetch_pc), 32'(model_pc));
    endtask

    task automatic calc_check(logic [PC_W-1:0] p1, logic [OFF_W-1:0] off,
                              logic [DATA_W-1:0] a, logic [DATA_W-1:0] b);
        ex_pc_plus1 = p1; ex_offset = off; ex_val_a = a; ex_val_b = b;
        #1;
        check(ex_target == exp_target(p1, off), "R8", "ex_target", 32'(ex_target), 32'(exp_target(p1, off)));
        check(ex_equal == (a == b), "R9", "ex_equal", 32'(ex_equal), 32'(a == b));
    endtask

    initial begin
        #100000;
        n_fail++; n_checks++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0; hazard_stall = 1'b0; mem_opcode = 3'd7; mem_equal = 1'b0; mem_target = '0;
        ex_pc_plus1 = '0; ex_offset = '0; ex_val_a = '0; ex_val_b = '0;
        // R1: reset state and reset vector
        step(1'b0, 1'b0, 3'd7, 1'b0, 16'h0000, "R1");
        step(1'b0, 1'b1, 3'd4, 1'b1, 16'h1234, "R1");
        // R2: sequential fetch
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 3'd0, 1'b0, 16'h0000, "R2");
        // R3: taken branch redirects next cycle
        step(1'b1, 1'b0, 3'd4, 1'b1, 16'hFFFE, "R3");
        // R2: wrap past 0xFFFF
        step(1'b1, 1'b0, 3'd7, 1'b0, 16'h0000, "R2");
        step(1'b1, 1'b0, 3'd7, 1'b0, 16'h0000, "R2");
        // R4: branch not equal falls through
        step(1'b1, 1'b0, 3'd4, 1'b0, 16'h0AAA, "R4");
        // R5: other opcodes ignore the equality flag
        for (int o = 0; o < 8; o++)
            if (o != 4) step(1'b1, 1'b0, 3'(o), 1'b1, 16'h0BBB, "R5");
        // R6: stall alone holds and bubbles
        step(1'b1, 1'b1, 3'd1, 1'b1, 16'h0CCC, "R6");
        step(1'b1, 1'b1, 3'd4, 1'b0, 16'h0CCC, "R6");
        // R7: squash overrides stall
        step(1'b1, 1'b1, 3'd4, 1'b1, 16'h4321, "R7");
        // R8/R9: directed arithmetic corners
        calc_check(16'h0010, 8'hFF, 32'd5, 32'd5);
        calc_check(16'h0000, 8'h80, 32'd1, 32'd2);
        calc_check(16'hFFFF, 8'h7F, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        // Random mix; stall and taken branches overlap often (R7)
        for (int i = 0; i < 400; i++) begin
            logic [2:0] op = ($urandom % 3 == 0) ? 3'd4 : 3'($urandom);
            logic st = ($urandom % 3 == 0);
            logic eq = 1'($urandom);
            string rq = exp_taken(op, eq) ? (st ? "R7" : "R3") : (st ? "R6" : "R2");
            step(1'b1, st, op, eq, 16'($urandom), rq);
            if (i % 8 == 0) begin
                logic [DATA_W-1:0] a = $urandom;
                calc_check(16'($urandom), 8'($urandom), a, ($urandom % 2 == 0) ? a : DATA_W'($urandom));
            end
        end
        // R1: reset again mid-run
        step(1'b0, 1'b1, 3'd4, 1'b1, 16'h7777, "R1");
        step(1'b1, 1'b0, 3'd2, 1'b0, 16'h0000, "R2");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule